// File: doc/BRIEF.md
# Inter-Processor Mailbox FIFO Bridge

This block links two processors, called side A and side B, that share one clock. Each side sees its own bank of four 32-bit registers: a sync register, a control/status register, a send-queue write port and a receive-queue read port. A word that one side writes to its send port is placed in a 16-word queue and is read, in order, from the other side's receive port. There is one queue in each direction.

Each side also publishes an 8-bit sync value that the other side can read at any time. A side can raise an interrupt on the other side by writing a trigger bit. Side A has two trigger bits, one for each of side B's two interrupt lines. Side B has one trigger bit, which drives side A's interrupt line. The interrupt lines also go high on queue-level conditions while those conditions are enabled. A sticky error flag records a write to a full send queue and a read from an empty receive queue.

The bus is a simple single-cycle strobe interface. `addr` is the word index, which is the byte offset divided by four. Read data is registered and is valid in the cycle after the read strobe.

Top module: `ipc_mailbox_bridge`

## Requirements
- R1: A word written at word index 2 (offset 0x8) on one side is returned, in first-in first-out order, by reads at word index 3 (offset 0xC) on the other side. Both directions work independently.
- R2: Sync register (index 0) bits [15:8] hold the byte the local side last wrote. Bits [7:0] always show the byte the remote side last wrote into its own bits [15:8]. Writes to bits [7:0] have no effect.
- R3: Writing 1 to a sync trigger bit makes the remote line high for exactly the one cycle after the write edge. This happens only if the remote sync bit 31 is 1. Side A bit 29 drives `b_irq` and side A bit 30 drives `b_irq_aux`. Side B bit 30 drives `a_irq`. Side B bit 29 has no effect.
- R4: Control register (index 1) status bits read as follows, with 1 meaning true: bit 0 is send queue empty, bit 1 is send queue full, bit 8 is receive queue empty, bit 9 is receive queue full. Bit 3 reads as 0.
- R5: Control bit 2 keeps the local interrupt line high while the send queue is not full. Control bit 10 keeps it high while the receive queue is not empty.
- R6: Writing 1 to control bit 3 empties the local send queue at that edge.
- R7: Control bit 14 is set by a send-port write while the send queue is full, or by a receive-port read while the receive queue is empty. It then stays set until it is cleared by writing 1 to bit 14.
- R8: While control bit 15 is 0, writes to the send port push nothing and reads from the receive port pop nothing.
- R9: Each queue holds 16 words. A write to a full queue is dropped.
- R10: A receive-port read that pops nothing returns the last word popped on that side, or 0 if nothing has been popped since reset.
- R11: After reset, all queues are empty and both sync bytes are 0. All enable bits, the error flags and all interrupt lines are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_wr_en | input | 1 | Side A write strobe |
| a_rd_en | input | 1 | Side A read strobe |
| a_addr | input | 2 | Side A word index (0 sync, 1 control, 2 send, 3 receive) |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, valid the cycle after the strobe |
| a_irq | output | 1 | Side A interrupt line |
| b_wr_en | input | 1 | Side B write strobe |
| b_rd_en | input | 1 | Side B read strobe |
| b_addr | input | 2 | Side B word index |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, valid the cycle after the strobe |
| b_irq | output | 1 | Side B main interrupt line |
| b_irq_aux | output | 1 | Side B second interrupt line, driven by side A trigger bit 29's sibling, bit 30 |

## Verification
The data path is driven in three patterns:
- Short bursts in each direction. These show ordering and independence of the two queues.
- A 17-word burst into a 16-word queue. This separates correct dropping and error marking from overwriting.
- Reads from an empty queue and reads made with the ports disabled. These show whether a read that pops nothing returns the held word, or whether it pops.

The trigger tests set the remote enable bit on, then off, and use each trigger bit in turn. This shows that each bit reaches the right line and that side B's bit 29 reaches none.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int WORD_W = 32;

    // word indices (byte offset / 4)
    localparam logic [1:0] IDX_SYNC = 2'd0;
    localparam logic [1:0] IDX_CTRL = 2'd1;
    localparam logic [1:0] IDX_SEND = 2'd2;
    localparam logic [1:0] IDX_RECV = 2'd3;

    // sync register bits
    localparam int SY_TRIG_LO = 29;
    localparam int SY_TRIG_HI = 30;
    localparam int SY_IRQ_EN  = 31;

    // control register bits
    localparam int CT_TX_EMPTY = 0;
    localparam int CT_TX_FULL  = 1;
    localparam int CT_TX_IE    = 2;
    localparam int CT_FLUSH    = 3;
    localparam int CT_RX_EMPTY = 8;
    localparam int CT_RX_FULL  = 9;
    localparam int CT_RX_IE    = 10;
    localparam int CT_ERR      = 14;
    localparam int CT_EN       = 15;

    typedef struct packed {
        logic [7:0]        sent_byte;
        logic              irq_en;
        logic              tx_ie;
        logic              rx_ie;
        logic              fifo_en;
        logic              err;
        logic              pulse_main;
        logic              pulse_aux;
        logic [WORD_W-1:0] last_word;
        logic [WORD_W-1:0] rdata;
    } port_state_t;

endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    input  logic [WIDTH-1:0] push_data,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic [CW-1:0]    count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] cnt;
    } fifo_state_t;

    fifo_state_t s_q, s_d;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    always_comb begin
        push_ok = push && (s_q.cnt != FULL_CNT) && !flush;
        pop_ok  = pop && (s_q.cnt != '0) && !flush;
        s_d     = s_q;
        if (flush) begin
            s_d.rd_ptr = s_q.wr_ptr;
            s_d.cnt    = '0;
        end else begin
            if (push_ok)
                s_d.wr_ptr = (s_q.wr_ptr == LAST_IDX) ? '0 : s_q.wr_ptr + 1'b1;
            if (pop_ok)
                s_d.rd_ptr = (s_q.rd_ptr == LAST_IDX) ? '0 : s_q.rd_ptr + 1'b1;
            if (push_ok && !pop_ok)
                s_d.cnt = s_q.cnt + 1'b1;
            else if (pop_ok && !push_ok)
                s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[s_q.wr_ptr] <= push_data;
    end

    assign head  = mem_q[s_q.rd_ptr];
    assign empty = (s_q.cnt == '0);
    assign full  = (s_q.cnt == FULL_CNT);
    assign count = s_q.cnt;

endmodule

// File: rtl/mbx_port.sv
module mbx_port
    import mbx_pkg::*;
#(
    parameter bit HAS_AUX = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic [7:0]        remote_byte,
    output logic [7:0]        local_byte,
    input  logic              tx_empty,
    input  logic              tx_full,
    input  logic              rx_empty,
    input  logic              rx_full,
    input  logic [WORD_W-1:0] rx_head,
    output logic              push,
    output logic [WORD_W-1:0] push_data,
    output logic              pop,
    output logic              flush,
    output logic              trig_main_out,
    output logic              trig_aux_out,
    input  logic              trig_main_in,
    input  logic              trig_aux_in,
    output logic              err,
    output logic              irq_main,
    output logic              irq_aux
);
    localparam int MAIN_BIT = HAS_AUX ? SY_TRIG_LO : SY_TRIG_HI;

    port_state_t s_q, s_d;
    logic wr_sync, wr_ctrl, wr_send, rd_recv, err_set, err_clr;
    logic [WORD_W-1:0] sync_view, ctrl_view, recv_view;

    always_comb begin
        wr_sync = wr_en && (addr == IDX_SYNC);
        wr_ctrl = wr_en && (addr == IDX_CTRL);
        wr_send = wr_en && (addr == IDX_SEND);
        rd_recv = rd_en && (addr == IDX_RECV);

        push      = wr_send && s_q.fifo_en;
        push_data = wdata;
        pop       = rd_recv && s_q.fifo_en;
        flush     = wr_ctrl && wdata[CT_FLUSH];

        trig_main_out = wr_sync && wdata[MAIN_BIT];
        trig_aux_out  = HAS_AUX ? (wr_sync && wdata[SY_TRIG_HI]) : 1'b0;

        err_set = (push && tx_full) || (pop && rx_empty);
        err_clr = wr_ctrl && wdata[CT_ERR];

        sync_view = '0;
        sync_view[7:0]       = remote_byte;
        sync_view[15:8]      = s_q.sent_byte;
        sync_view[SY_IRQ_EN] = s_q.irq_en;

        ctrl_view = '0;
        ctrl_view[CT_TX_EMPTY] = tx_empty;
        ctrl_view[CT_TX_FULL]  = tx_full;
        ctrl_view[CT_TX_IE]    = s_q.tx_ie;
        ctrl_view[CT_RX_EMPTY] = rx_empty;
        ctrl_view[CT_RX_FULL]  = rx_full;
        ctrl_view[CT_RX_IE]    = s_q.rx_ie;
        ctrl_view[CT_ERR]      = s_q.err;
        ctrl_view[CT_EN]       = s_q.fifo_en;

        recv_view = (pop && !rx_empty) ? rx_head : s_q.last_word;

        s_d = s_q;
        if (wr_sync) begin
            s_d.sent_byte = wdata[15:8];
            s_d.irq_en    = wdata[SY_IRQ_EN];
        end
        if (wr_ctrl) begin
            s_d.tx_ie   = wdata[CT_TX_IE];
            s_d.rx_ie   = wdata[CT_RX_IE];
            s_d.fifo_en = wdata[CT_EN];
        end
        s_d.err        = err_set || (s_q.err && !err_clr);
        s_d.pulse_main = trig_main_in && s_q.irq_en;
        s_d.pulse_aux  = trig_aux_in && s_q.irq_en;
        s_d.last_word  = recv_view;
        if (rd_en) begin
            unique case (addr)
                IDX_SYNC: s_d.rdata = sync_view;
                IDX_CTRL: s_d.rdata = ctrl_view;
                IDX_SEND: s_d.rdata = '0;
                default:  s_d.rdata = recv_view;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata      = s_q.rdata;
    assign local_byte = s_q.sent_byte;
    assign err        = s_q.err;
    assign irq_main   = s_q.pulse_main
                      || (s_q.tx_ie && !tx_full)
                      || (s_q.rx_ie && !rx_empty);
    assign irq_aux    = s_q.pulse_aux;

endmodule

// File: rtl/ipc_mailbox_bridge.sv
module ipc_mailbox_bridge
    import mbx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        a_wr_en,
    input  logic        a_rd_en,
    input  logic [1:0]  a_addr,
    input  logic [31:0] a_wdata,
    output logic [31:0] a_rdata,
    output logic        a_irq,
    input  logic        b_wr_en,
    input  logic        b_rd_en,
    input  logic [1:0]  b_addr,
    input  logic [31:0] b_wdata,
    output logic [31:0] b_rdata,
    output logic        b_irq,
    output logic        b_irq_aux
);
    localparam int CW = $clog2(DEPTH + 1);

    // A -> B queue
    logic              ab_empty, ab_full;
    logic [CW-1:0]     ab_count;
    logic [WORD_W-1:0] ab_head;
    // B -> A queue
    logic              ba_empty, ba_full;
    logic [CW-1:0]     ba_count;
    logic [WORD_W-1:0] ba_head;

    logic              a_push, a_pop, a_flush, b_push, b_pop, b_flush;
    logic [WORD_W-1:0] a_push_data, b_push_data;
    logic [7:0]        a_byte, b_byte;
    logic              a_trig_main, a_trig_aux, b_trig_main;
    logic              a_err, b_err;
    logic              b_trig_aux_unused, a_irq_aux_unused;

    mbx_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH), .CW(CW)) u_q_ab (
        .clk(clk), .rst_n(rst_n), .push(a_push), .pop(b_pop), .flush(a_flush),
        .push_data(a_push_data), .head(ab_head), .empty(ab_empty),
        .full(ab_full), .count(ab_count)
    );

    mbx_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH), .CW(CW)) u_q_ba (
        .clk(clk), .rst_n(rst_n), .push(b_push), .pop(a_pop), .flush(b_flush),
        .push_data(b_push_data), .head(ba_head), .empty(ba_empty),
        .full(ba_full), .count(ba_count)
    );

    mbx_port #(.HAS_AUX(1'b1)) u_port_a (
        .clk(clk), .rst_n(rst_n), .wr_en(a_wr_en), .rd_en(a_rd_en),
        .addr(a_addr), .wdata(a_wdata), .rdata(a_rdata),
        .remote_byte(b_byte), .local_byte(a_byte),
        .tx_empty(ab_empty), .tx_full(ab_full),
        .rx_empty(ba_empty), .rx_full(ba_full), .rx_head(ba_head),
        .push(a_push), .push_data(a_push_data), .pop(a_pop), .flush(a_flush),
        .trig_main_out(a_trig_main), .trig_aux_out(a_trig_aux),
        .trig_main_in(b_trig_main), .trig_aux_in(1'b0),
        .err(a_err), .irq_main(a_irq), .irq_aux(a_irq_aux_unused)
    );

    mbx_port #(.HAS_AUX(1'b0)) u_port_b (
        .clk(clk), .rst_n(rst_n), .wr_en(b_wr_en), .rd_en(b_rd_en),
        .addr(b_addr), .wdata(b_wdata), .rdata(b_rdata),
        .remote_byte(a_byte), .local_byte(b_byte),
        .tx_empty(ba_empty), .tx_full(ba_full),
        .rx_empty(ab_empty), .rx_full(ab_full), .rx_head(ab_head),
        .push(b_push), .push_data(b_push_data), .pop(b_pop), .flush(b_flush),
        .trig_main_out(b_trig_main), .trig_aux_out(b_trig_aux_unused),
        .trig_main_in(a_trig_main), .trig_aux_in(a_trig_aux),
        .err(b_err), .irq_main(b_irq), .irq_aux(b_irq_aux)
    );

endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          a_wr_en,
    input logic [1:0]    a_addr,
    input logic [31:0]   a_wdata,
    input logic          a_flush,
    input logic          b_flush,
    input logic          b_pop,
    input logic          ab_empty,
    input logic          ab_full,
    input logic          ba_empty,
    input logic [CW-1:0] ab_count,
    input logic          a_err,
    input logic          b_irq_aux
);
    // R6: a flush leaves the sender's queue empty
    a_r6_flush_ab: assert property (@(posedge clk) disable iff (!rst_n)
        a_flush |=> ab_empty);
    a_r6_flush_ba: assert property (@(posedge clk) disable iff (!rst_n)
        b_flush |=> ba_empty);

    // R9: a full queue stays full unless drained or flushed
    a_r9_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_full && !b_pop && !a_flush) |=> ab_full);

    // R9: occupancy never exceeds the depth
    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ab_count <= CW'(DEPTH));

    // R3: the second line on side B only follows a side A bit-30 sync write
    a_r3_aux_source: assert property (@(posedge clk) disable iff (!rst_n)
        b_irq_aux |-> $past(a_wr_en && (a_addr == 2'd0) && a_wdata[30]));

    // R7: error flag stays until written with 1
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (a_err && !(a_wr_en && (a_addr == 2'd1) && a_wdata[14])) |=> a_err);
endmodule

bind ipc_mailbox_bridge mbx_checker #(.DEPTH(DEPTH)) u_mbx_checker (
    .clk(clk), .rst_n(rst_n), .a_wr_en(a_wr_en), .a_addr(a_addr),
    .a_wdata(a_wdata), .a_flush(a_flush), .b_flush(b_flush), .b_pop(b_pop),
    .ab_empty(ab_empty), .ab_full(ab_full), .ba_empty(ba_empty),
    .ab_count(ab_count), .a_err(a_err), .b_irq_aux(b_irq_aux)
);

// File: tb/test_ipc_mailbox_bridge.sv
module test_ipc_mailbox_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_wr_en = 0, a_rd_en = 0, b_wr_en = 0, b_rd_en = 0;
    logic [1:0]  a_addr = 0, b_addr = 0;
    logic [31:0] a_wdata = 0, b_wdata = 0;
    logic [31:0] a_rdata, b_rdata;
    logic        a_irq, b_irq, b_irq_aux;

    int total = 0;
    int bad = 0;
    logic [31:0] q_ab[$];
    logic [31:0] q_ba[$];
    logic [31:0] last_b = 0;
    logic [31:0] rd;

    always #5 clk = ~clk;

    ipc_mailbox_bridge i_ipc_mailbox_bridge (
        .clk(clk), .rst_n(rst_n),
        .a_wr_en(a_wr_en), .a_rd_en(a_rd_en), .a_addr(a_addr), .a_wdata(a_wdata),
        .a_rdata(a_rdata), .a_irq(a_irq),
        .b_wr_en(b_wr_en), .b_rd_en(b_rd_en), .b_addr(b_addr), .b_wdata(b_wdata),
        .b_rdata(b_rdata), .b_irq(b_irq), .b_irq_aux(b_irq_aux)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input bit side, input logic [1:0] idx, input logic [31:0] d);
        @(negedge clk);
        if (!side) begin a_wr_en = 1; a_addr = idx; a_wdata = d; end
        else       begin b_wr_en = 1; b_addr = idx; b_wdata = d; end
        @(negedge clk);
        a_wr_en = 0; b_wr_en = 0;
    endtask

    task automatic bus_rd(input bit side, input logic [1:0] idx, output logic [31:0] d);
        @(negedge clk);
        if (!side) begin a_rd_en = 1; a_addr = idx; end
        else       begin b_rd_en = 1; b_addr = idx; end
        @(negedge clk);
        a_rd_en = 0; b_rd_en = 0;
        d = side ? b_rdata : a_rdata;
    endtask

    // driver: send a word and record what the far side must later see
    task automatic send(input bit side, input logic [31:0] w);
        bus_wr(side, 2'd2, w);
        if (!side) begin if (q_ab.size() < 16) q_ab.push_back(w); end
        else       begin if (q_ba.size() < 16) q_ba.push_back(w); end
    endtask

    // monitor: pop from the receiving side and compare with the scoreboard
    task automatic recv_check(input bit side, input string req);
        logic [31:0] got, exp;
        bus_rd(side, 2'd3, got);
        if (side) begin
            exp = (q_ab.size() > 0) ? q_ab.pop_front() : last_b;
            last_b = exp;
        end else begin
            exp = (q_ba.size() > 0) ? q_ba.pop_front() : 32'h0;
        end
        check(req, got, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state, R4 status encoding
        bus_rd(0, 2'd1, rd); check("R11 A ctrl after reset", rd, 32'h0000_0101);
        bus_rd(1, 2'd0, rd); check("R11 B sync after reset", rd, 32'h0);
        check("R11 irq lines idle", {29'd0, a_irq, b_irq, b_irq_aux}, 32'h0);
        // R10 empty read before any pop returns 0
        bus_rd(0, 2'd3, rd); check("R10 A empty read after reset", rd, 32'h0);

        bus_wr(0, 2'd1, 32'h0000_8000);
        bus_wr(1, 2'd1, 32'h0000_8000);

        // R2 sync mirror
        bus_wr(0, 2'd0, 32'h0000_5AFF);
        bus_rd(1, 2'd0, rd); check("R2 B sees A byte", rd, 32'h0000_005A);
        bus_wr(1, 2'd0, 32'h0000_3C00);
        bus_rd(0, 2'd0, rd); check("R2 A sync view", rd, 32'h0000_5A3C);

        // R1 both directions
        send(0, 32'h1111_0001); send(0, 32'h1111_0002); send(0, 32'h1111_0003);
        send(1, 32'h2222_0001); send(1, 32'h2222_0002);
        for (int i = 0; i < 3; i++) recv_check(1, "R1 A to B order");
        for (int i = 0; i < 2; i++) recv_check(0, "R1 B to A order");

        // R9 overflow, R7 error set, R4 full bits
        for (int i = 0; i < 17; i++) send(0, 32'hA000_0000 + 32'(i));
        bus_rd(0, 2'd1, rd); check("R9 R7 A ctrl full with error", rd, 32'h0000_C102);
        bus_rd(1, 2'd1, rd); check("R4 B ctrl rx full", rd, 32'h0000_8201);
        for (int i = 0; i < 16; i++) recv_check(1, "R9 drained words");
        bus_rd(0, 2'd1, rd); check("R7 error still set", rd[31:0], 32'h0000_C101);
        bus_wr(0, 2'd1, 32'h0000_C000);
        bus_rd(0, 2'd1, rd); check("R7 error cleared", rd, 32'h0000_8101);

        // R10 underrun returns last word, sets error
        bus_rd(1, 2'd3, rd); check("R10 B empty read", rd, 32'hA000_000F);
        bus_rd(1, 2'd1, rd); check("R7 underrun error", rd, 32'h0000_C101);
        bus_wr(1, 2'd1, 32'h0000_C000);

        // R8 sender disabled
        bus_wr(0, 2'd1, 32'h0);
        bus_wr(0, 2'd2, 32'hDEAD_0001);
        bus_rd(1, 2'd1, rd); check("R8 disabled push ignored", rd, 32'h0000_8101);
        bus_wr(0, 2'd1, 32'h0000_8000);
        // R8 receiver disabled
        send(0, 32'h5555_0001);
        bus_wr(1, 2'd1, 32'h0);
        bus_rd(1, 2'd3, rd); check("R8 disabled read holds last", rd, 32'hA000_000F);
        bus_rd(1, 2'd1, rd); check("R8 word still queued", rd, 32'h0000_0001);
        bus_wr(1, 2'd1, 32'h0000_8000);
        recv_check(1, "R8 word after re-enable");

        // R6 flush
        send(0, 32'h6666_0001); send(0, 32'h6666_0002);
        bus_wr(0, 2'd1, 32'h0000_8008);
        q_ab.delete();
        bus_rd(0, 2'd1, rd); check("R6 A ctrl after flush", rd, 32'h0000_8101);
        bus_rd(1, 2'd1, rd); check("R6 B rx empty after flush", rd, 32'h0000_8101);

        // R5 level interrupts
        bus_wr(1, 2'd1, 32'h0000_8400);
        check("R5 rx ie with empty queue", {31'd0, b_irq}, 32'd0);
        send(0, 32'h7777_0001);
        check("R5 rx not empty irq", {31'd0, b_irq}, 32'd1);
        recv_check(1, "R5 pop");
        check("R5 irq drops when empty", {31'd0, b_irq}, 32'd0);
        bus_wr(1, 2'd1, 32'h0000_8000);
        bus_wr(0, 2'd1, 32'h0000_8004);
        check("R5 tx not full irq", {31'd0, a_irq}, 32'd1);
        bus_wr(0, 2'd1, 32'h0000_8000);
        check("R5 tx ie off", {31'd0, a_irq}, 32'd0);

        // R3 triggers
        bus_wr(0, 2'd0, 32'h2000_0000);
        check("R3 blocked without remote enable", {30'd0, b_irq, b_irq_aux}, 32'd0);
        bus_wr(1, 2'd0, 32'h8000_0000);
        bus_wr(0, 2'd0, 32'h2000_0000);
        check("R3 bit29 pulses b_irq", {30'd0, b_irq, b_irq_aux}, 32'd2);
        @(negedge clk);
        check("R3 pulse one cycle", {30'd0, b_irq, b_irq_aux}, 32'd0);
        bus_wr(0, 2'd0, 32'h4000_0000);
        check("R3 bit30 pulses b_irq_aux", {30'd0, b_irq, b_irq_aux}, 32'd1);
        @(negedge clk);
        check("R3 aux one cycle", {31'd0, b_irq_aux}, 32'd0);
        bus_wr(1, 2'd0, 32'hC000_0000);
        check("R3 A not enabled", {31'd0, a_irq}, 32'd0);
        bus_wr(0, 2'd0, 32'h8000_0000);
        bus_wr(1, 2'd0, 32'hC000_0000);
        check("R3 B bit30 pulses a_irq", {31'd0, a_irq}, 32'd1);
        @(negedge clk);
        check("R3 a_irq one cycle", {31'd0, a_irq}, 32'd0);
        bus_wr(1, 2'd0, 32'hA000_0000);
        check("R3 B bit29 unused", {31'd0, a_irq}, 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule